// File: doc/BRIEF.md
# Error-Correcting Memory Front End with Partial-Store Merge

This block sits between a simple request/response port and a synchronous on-chip memory whose words are wider than the bus data. Each 32-bit data word is stored with a 7-bit check code built from an extended Hamming code (six position parity bits plus one overall parity bit). The code has minimum distance 4, so any single flipped bit in a stored word is corrected and any two flipped bits are detected.

A store that covers all four byte lanes goes to memory as one write. A store that covers fewer lanes becomes an internal sequence: read the old word, correct it if needed, merge in the enabled lanes, re-encode it and write it back. The request port refuses new work while that sequence runs. Read data is checked and corrected in the cycle it comes back from memory. A corrected-error flag pulses alongside the corrected data. An uncorrectable word produces an error response.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: A write with all four strobes set causes exactly one memory write, in the cycle it is accepted. It causes no memory read. Its response comes one cycle later with `rsp_err` 0.
- R3: A read is issued to memory in its acceptance cycle. Its response, carrying the stored data, comes one cycle later.
- R4: A read of a word with any one of its 39 stored bits flipped returns the original data with no extra latency. `rsp_corrected` is 1 in that response cycle and only there, and `rsp_err` is 0.
- R5: A read of a word with two stored bits flipped gives `rsp_valid` with `rsp_err` 1 and `rsp_corrected` 0.
- R6: A write with some but not all strobes set performs one memory read in its acceptance cycle and one memory write in the next cycle. Strobe bit i selects data bits 8i+7..8i. Lanes that are not enabled keep their old value. The response comes two cycles after acceptance.
- R7: `req_ready` is 0 in the cycle after a partial write is accepted, so no other request is accepted between its read and its write.
- R8: If the old word read for a partial write is uncorrectable, no memory write occurs. The error response (`rsp_err` 1) comes one cycle after acceptance, and the stored word is unchanged.
- R9: If the old word read for a partial write has one flipped bit, the merge uses the corrected data. The word written back is clean, so a later read of it shows `rsp_corrected` 0.
- R10: `mem_we` is never 1 while `mem_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | AW | Word address |
| req_wstrb | input | 4 | Byte-lane enables for stores |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Uncorrectable data error |
| rsp_corrected | output | 1 | Read data had a single-bit error that was corrected |
| rsp_rdata | output | 32 | Load data (zero on store responses) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 39 | Encoded word to memory |
| mem_rdata | input | 39 | Encoded word from memory, one cycle after a read |

## Verification
The bound checker watches the handshake and the response flags on every cycle. It checks that a write enable never appears without an access enable. It checks that the corrected and error flags appear only with a response and never together. It checks that a partial store starts with a read and blocks the port in the next cycle. It checks that full stores and loads are answered one cycle after acceptance. Which bits get corrected, the merged contents, the abort of a write after an uncorrectable read, and the clean write-back after a corrected merge depend on the stored data. The bench shows these by flipping bits in its memory model and reading words back.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int HAM_BITS = 6;
    localparam int CODE_W   = DATA_W + HAM_BITS + 1;

    typedef enum logic { ST_IDLE, ST_MERGE } ctrl_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single;
        logic              dbl;
    } dec_result_t;

    // Bit 0 of the code word is overall parity; bits 1..CODE_W-1 are Hamming
    // positions, with check bits at powers of two and data everywhere else.
    function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < HAM_BITS; j++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (p[j]) x = x ^ c[p];
            end
            c[1 << j] = x;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    function automatic dec_result_t ecc_decode(input logic [CODE_W-1:0] c);
        dec_result_t       r;
        logic [HAM_BITS-1:0] s;
        logic [CODE_W-1:0] fixed;
        logic              par;
        int                k;
        s = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (c[p]) s = s ^ p[HAM_BITS-1:0];
        end
        par      = ^c;
        fixed    = c;
        r.single = 1'b0;
        r.dbl    = 1'b0;
        if (par) begin
            if (int'(s) < CODE_W) begin
                fixed[s] = ~fixed[s];
                r.single = 1'b1;
            end else begin
                r.dbl = 1'b1;
            end
        end else if (s != '0) begin
            r.dbl = 1'b1;
        end
        k = 0;
        r.data = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = fixed[p];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb code_out = ecc_encode(data_in);
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              err_single,
    output logic              err_double
);
    dec_result_t res;
    always_comb begin
        res        = ecc_decode(code_in);
        data_out   = res.data;
        err_single = res.single;
        err_double = res.dbl;
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] old_data,
    input  logic [DATA_W-1:0] new_data,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = lane_en[i] ? new_data[8*i +: 8] : old_data[8*i +: 8];
    end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
    import ecc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [LANES-1:0]  req_wstrb,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_corrected,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata
);

    ctrl_state_t       state_q;
    logic              rd_pend_q;
    logic              wr_ack_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  wstrb_q;

    logic              accept;
    logic              full_wr;
    logic              in_merge;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] enc_src;
    logic [CODE_W-1:0] enc_code;

    assign in_merge  = (state_q == ST_MERGE);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign full_wr   = req_write && (&req_wstrb);

    secded_decoder u_dec (
        .code_in    (mem_rdata),
        .data_out   (dec_data),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    lane_merge u_merge (
        .old_data (dec_data),
        .new_data (wdata_q),
        .lane_en  (wstrb_q),
        .merged   (merged)
    );

    assign enc_src = in_merge ? merged : req_wdata;

    secded_encoder u_enc (
        .data_in  (enc_src),
        .code_out (enc_code)
    );

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = enc_code;
        if (in_merge) begin
            mem_en   = !dec_double;
            mem_we   = !dec_double;
            mem_addr = addr_q;
        end else if (accept) begin
            mem_en = 1'b1;
            mem_we = full_wr;
        end
    end

    assign rsp_valid     = rd_pend_q || wr_ack_q || (in_merge && dec_double);
    assign rsp_err       = (rd_pend_q || in_merge) && dec_double;
    assign rsp_corrected = rd_pend_q && dec_single;
    assign rsp_rdata     = rd_pend_q ? dec_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rd_pend_q <= 1'b0;
            wr_ack_q  <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            wstrb_q   <= '0;
        end else begin
            rd_pend_q <= accept && !req_write;
            wr_ack_q  <= (accept && full_wr) || (in_merge && !dec_double);
            if (in_merge) begin
                state_q <= ST_IDLE;
            end else if (accept && req_write && !full_wr) begin
                state_q <= ST_MERGE;
            end
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wstrb_q <= req_wstrb;
            end
        end
    end

endmodule

// File: rtl/ecc_rmw_ctrl_chk.sv
module ecc_rmw_ctrl_chk
    import ecc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [LANES-1:0] req_wstrb,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             rsp_corrected,
    input logic             mem_en,
    input logic             mem_we
);
    logic acc;
    logic acc_part;
    assign acc      = req_valid && req_ready;
    assign acc_part = acc && req_write && !(&req_wstrb);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && req_ready));

    a_r10_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    a_r4_corr_only_with_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_corrected |-> (rsp_valid && !rsp_err));

    a_r5_err_only_with_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);

    a_r6_partial_reads_first: assert property (@(posedge clk) disable iff (rst)
        acc_part |-> (mem_en && !mem_we));

    a_r7_locked_during_merge: assert property (@(posedge clk) disable iff (rst)
        acc_part |=> !req_ready);

    a_r2_full_write_answer: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && (&req_wstrb)) |=> (rsp_valid && !rsp_err));

    a_r3_read_answer: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write) |=> rsp_valid);

endmodule

bind ecc_rmw_ctrl ecc_rmw_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_wstrb     (req_wstrb),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_corrected (rsp_corrected),
    .mem_en        (mem_en),
    .mem_we        (mem_we)
);

// File: tb/ecc_rmw_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_rmw_ctrl_tb;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_wstrb = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_corrected;
    logic [31:0] rsp_rdata;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [38:0] mem_wdata;
    logic [38:0] mem_rdata;

    logic [38:0] mem [256];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          bad_we = 0;
    logic        inj_go = 1'b0;
    logic [7:0]  inj_addr = '0;
    logic [38:0] inj_mask = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ecc_rmw_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wstrb(req_wstrb), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_corrected(rsp_corrected),
        .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        if (mem_we && !mem_en) bad_we <= bad_we + 1;
        if (inj_go) begin
            mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end else if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_exp(input logic [31:0] oldv, input logic [31:0] newv,
                                             input logic [3:0] s);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = s[i] ? newv[8*i +: 8] : oldv[8*i +: 8];
        return r;
    endfunction

    task automatic inject(input logic [7:0] a, input logic [38:0] m);
        @(negedge clk);
        inj_addr = a;
        inj_mask = m;
        inj_go   = 1'b1;
        @(negedge clk);
        inj_go   = 1'b0;
    endtask

    task automatic do_req(input logic wr, input logic [7:0] a, input logic [3:0] s,
                          input logic [31:0] d, output logic [31:0] q, output logic e,
                          output logic c, output int lat, output int nw, output int nr);
        int w0, r0;
        @(negedge clk);
        w0 = wr_cnt;
        r0 = rd_cnt;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wstrb = s;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        q = rsp_rdata;
        e = rsp_err;
        c = rsp_corrected;
        @(negedge clk);
        nw = wr_cnt - w0;
        nr = rd_cnt - r0;
    endtask

    logic [31:0] shadow [16];
    bit          dirty  [16];

    initial begin
        logic [31:0] q;
        logic        e, c;
        int          lat, nw, nr;
        logic [31:0] base;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);

        // R2 full write
        base = 32'hCAFE_1234;
        do_req(1'b1, 8'd40, 4'hF, base, q, e, c, lat, nw, nr);
        chk(nw == 1 && nr == 0, "R2 mem ops (writes,reads)", {nw[31:0], nr[31:0]}, {32'd1, 32'd0});
        chk(lat == 1 && e == 1'b0, "R2 latency/err", {lat[31:0], 31'd0, e}, {32'd1, 32'd0});

        // R3 read back
        do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
        chk(q == base, "R3 read data", q, base);
        chk(lat == 1 && nr == 1 && c == 1'b0, "R3 latency/reads/corr", {lat[31:0], nr[31:0]}, {32'd1, 32'd1});

        // R4 every single-bit position corrected
        for (int b = 0; b < 39; b++) begin
            inject(8'd40, 39'd1 << b);
            do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
            chk(q == base && c == 1'b1 && e == 1'b0 && lat == 1, "R4 corrected read",
                {q, 29'd0, c, e, lat[0]}, {base, 29'd0, 3'b101});
            inject(8'd40, 39'd1 << b);
        end
        do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
        chk(c == 1'b0, "R4 no pulse on clean read", c, 0);

        // R5 double errors detected
        for (int k = 0; k < 8; k++) begin
            int b1, b2;
            b1 = $urandom_range(0, 38);
            b2 = (b1 + 1 + $urandom_range(0, 37)) % 39;
            inject(8'd40, (39'd1 << b1) | (39'd1 << b2));
            do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
            chk(e == 1'b1 && c == 1'b0, "R5 double detect", {e, c}, 2'b10);
            inject(8'd40, (39'd1 << b1) | (39'd1 << b2));
        end

        // R6 partial write merges lanes
        do_req(1'b1, 8'd40, 4'b0101, 32'h1122_3344, q, e, c, lat, nw, nr);
        chk(lat == 2 && nr == 1 && nw == 1 && e == 1'b0, "R6 rmw latency/ops",
            {lat[15:0], nr[15:0], nw[15:0], 15'd0, e}, {16'd2, 16'd1, 16'd1, 16'd0});
        base = merge_exp(base, 32'h1122_3344, 4'b0101);
        do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
        chk(q == base, "R6 merged data", q, base);

        // R7 lock: second request held off during merge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd40;
        req_wstrb = 4'b0011; req_wdata = 32'hAAAA_BBBB;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b0; req_wstrb = 4'h0;
        chk(req_ready == 1'b0, "R7 ready low in merge", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && req_ready == 1'b1, "R7 write ack then ready", {rsp_valid, req_ready}, 2'b11);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        base = merge_exp(base, 32'hAAAA_BBBB, 4'b0011);
        chk(rsp_valid == 1'b1 && rsp_rdata == base, "R7 held read sees merged", rsp_rdata, base);
        @(negedge clk);

        // R8 uncorrectable old word aborts write
        inject(8'd40, 39'h3);
        do_req(1'b1, 8'd40, 4'b1000, 32'h5500_0000, q, e, c, lat, nw, nr);
        chk(e == 1'b1 && lat == 1 && nw == 0, "R8 abort (err,lat,writes)",
            {31'd0, e, lat[15:0], nw[15:0]}, {31'd0, 1'b1, 16'd1, 16'd0});
        inject(8'd40, 39'h3);
        do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
        chk(q == base && e == 1'b0, "R8 memory unchanged", q, base);

        // R9 corrected old word, clean write-back
        inject(8'd40, 39'd1 << 17);
        do_req(1'b1, 8'd40, 4'b0010, 32'h0000_9900, q, e, c, lat, nw, nr);
        chk(e == 1'b0 && nw == 1, "R9 rmw completes", {e, nw[7:0]}, {1'b0, 8'd1});
        base = merge_exp(base, 32'h0000_9900, 4'b0010);
        do_req(1'b0, 8'd40, 4'h0, '0, q, e, c, lat, nw, nr);
        chk(q == base && c == 1'b0, "R9 clean merged word", {q, c}, {base, 1'b0});

        // Random mix against a shadow model
        for (int i = 0; i < 16; i++) begin
            shadow[i] = $urandom;
            dirty[i]  = 1'b0;
            do_req(1'b1, 8'(i), 4'hF, shadow[i], q, e, c, lat, nw, nr);
        end
        for (int n = 0; n < 400; n++) begin
            int          a, op;
            logic [3:0]  s;
            logic [31:0] d;
            a  = $urandom_range(0, 15);
            op = $urandom_range(0, 2);
            d  = $urandom;
            s  = 4'($urandom_range(1, 15));
            if (!dirty[a] && $urandom_range(0, 3) == 0) begin
                inject(8'(a), 39'd1 << $urandom_range(0, 38));
                dirty[a] = 1'b1;
            end
            if (op == 0) begin
                do_req(1'b0, 8'(a), 4'h0, '0, q, e, c, lat, nw, nr);
                chk(q == shadow[a] && c == dirty[a] && !e, "R3/R4 random read",
                    {q, c}, {shadow[a], dirty[a]});
            end else begin
                if (op == 1) s = 4'hF;
                do_req(1'b1, 8'(a), s, d, q, e, c, lat, nw, nr);
                shadow[a] = merge_exp(shadow[a], d, s);
                dirty[a]  = 1'b0;
                chk(!e && lat == ((s == 4'hF) ? 1 : 2), "R2/R6 random write latency",
                    lat, (s == 4'hF) ? 1 : 2);
            end
        end

        // R10 write enable never without access enable
        chk(bad_we == 0, "R10 stray write enable", bad_we, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
    end

endmodule